// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether each incoming frame is kept. Frame bytes arrive one per cycle, qualified by a valid strobe, and the first byte of a frame carries a start marker. The block captures the six destination-address bytes. It then produces a single accept or drop decision for the frame, together with a one-cycle strobe.

Unicast destinations are compared against a small table of exact addresses. Entry 0 is meant for the station's own address, and each entry has its own enable. Group destinations other than broadcast are looked up in a hash bin table. The bin is taken from a reflected CRC-32 of the address. Broadcast has its own block bit. Three override modes exist: promiscuous, pass-all-multicast and a debug receive-all. All state is loaded through a plain write port made of enable, address and data.

Top module: `rx_da_filter`

## Requirements
- R1: The decision strobe `dec_valid_o` is high for exactly one cycle: the cycle right after the clock edge that captured the sixth address byte of a frame. Bytes that follow the sixth, up to the next start marker, produce no further strobe.
- R2: A byte with `byte_valid_i` and `sof_i` both high restarts capture as address byte 0. A frame cut off by a new start marker before its sixth byte gets no strobe. Cycles with `byte_valid_i` low are skipped and do not count as bytes.
- R3: The exact-match entry i is written through two registers. Address 16+2i holds address bytes 0..3 in bits 7:0 through 31:24. Address 17+2i holds bytes 4..5 in bits 7:0 and 15:8, with the entry enable in bit 31. A unicast frame (bit 0 of byte 0 clear) is accepted when some enabled entry equals its address, and is dropped otherwise.
- R4: The bin index is computed as follows. Run a reflected CRC-32 over the six address bytes, each byte least significant bit first, starting from all ones with polynomial 0xEDB88320. Invert the result, reverse it across 32 bits, and take the top log2(HASH_BINS) bits. Hash word w sits at address 8+w. Its number is the index shifted right by five, and the low five index bits select the bit within the word.
- R5: With hash mode on (control bit 2), a non-broadcast group frame is accepted exactly when its bin bit is set. With hash mode off, such a frame is dropped.
- R6: Pass-all-multicast (control bit 1) accepts every group frame without looking at the hash table.
- R7: A broadcast destination (all ones) is accepted unless broadcast-block (control bit 4) is set, and this holds regardless of the hash and pass-all-multicast settings.
- R8: Promiscuous mode (control bit 0) accepts every frame.
- R9: Receive-all (control bit 3) accepts every frame.
- R10: After reset there is no strobe, the control register is clear, and all table state is clear. So unicast and multicast frames are dropped and broadcast is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Frame byte present this cycle |
| sof_i | input | 1 | Byte is the first of a frame |
| byte_i | input | 8 | Frame byte |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | CFG_AW | Register word address (0 control, 8+ hash, 16+ exact table) |
| cfg_wdata_i | input | 32 | Register write data |
| dec_valid_o | output | 1 | Decision strobe |
| dec_accept_o | output | 1 | Frame accepted (qualified by dec_valid_o) |

## Verification
The bench builds the filter with 128 hash bins and four exact-match entries. The four hash words mean the word-select part of the bin index carries two bits, so mapping errors in the upper index bits show up, not just a low/high split. Four entries let one entry be programmed but disabled while others stay live. The model also replays truncated frames, gaps between bytes and trailing bytes, each mixed with random control settings.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;

  localparam int DA_BYTES  = 6;
  localparam int DA_W      = 8 * DA_BYTES;
  localparam int CTRL_ADDR = 0;
  localparam int HASH_BASE = 8;
  localparam int UC_BASE   = 16;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  // bit 0 = promisc ... bit 4 = bcast_block
  typedef struct packed {
    logic bcast_block;
    logic recv_all;
    logic hash_en;
    logic all_mcast;
    logic promisc;
  } flt_ctrl_t;

  function automatic logic [31:0] da_crc32(input logic [DA_W-1:0] da);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int i = 0; i < DA_W; i++) begin
      fb = c[0] ^ da[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = x[i];
    return r;
  endfunction

endpackage

// File: rtl/da_capture.sv
module da_capture
  import rx_da_filter_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            byte_valid_i,
  input  logic            sof_i,
  input  logic [7:0]      byte_i,
  output logic [DA_W-1:0] da_o,
  output logic            done_o
);
  localparam int CNT_W = $clog2(DA_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DA_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DA_BYTES);

  logic [7:0]       da_q [DA_BYTES];
  logic [CNT_W-1:0] cnt_q;   // 0: idle, FULL: address complete
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < DA_BYTES; i++) da_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (byte_valid_i) begin
        if (sof_i) begin
          da_q[0] <= byte_i;
          cnt_q   <= CNT_W'(1);
        end else if (cnt_q != '0 && cnt_q < FULL) begin
          da_q[cnt_q] <= byte_i;
          cnt_q       <= cnt_q + CNT_W'(1);
          done_q      <= (cnt_q == LAST);
        end
      end
    end
  end

  for (genvar g = 0; g < DA_BYTES; g++) begin : g_pack
    assign da_o[8*g +: 8] = da_q[g];
  end
  assign done_o = done_q;

  // R2
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && sof_i |=> cnt_q == CNT_W'(1));

endmodule

// File: rtl/uc_match.sv
module uc_match
  import rx_da_filter_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int AW      = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [31:0]     cfg_wdata_i,
  input  logic [DA_W-1:0] da_i,
  output logic            hit_o
);
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [AW-1:0] LO_A = AW'(UC_BASE + 2*e);
    localparam logic [AW-1:0] HI_A = AW'(UC_BASE + 2*e + 1);
    logic [DA_W-1:0] addr_q;
    logic            en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
        en_q   <= 1'b0;
      end else if (cfg_we_i) begin
        if (cfg_addr_i == LO_A) addr_q[31:0] <= cfg_wdata_i;
        if (cfg_addr_i == HI_A) begin
          addr_q[DA_W-1:32] <= cfg_wdata_i[DA_W-33:0];
          en_q              <= cfg_wdata_i[31];
        end
      end
    end

    assign match[e] = en_q && (addr_q == da_i);
  end

  assign hit_o = |match;

endmodule

// File: rtl/mc_hash.sv
module mc_hash
  import rx_da_filter_pkg::*;
#(
  parameter int BINS = 64,
  parameter int AW   = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [31:0]     cfg_wdata_i,
  input  logic [DA_W-1:0] da_i,
  output logic            hit_o
);
  localparam int IDX_W = $clog2(BINS);
  localparam int WORDS = BINS / 32;
  localparam int SEL_W = IDX_W - 5;

  logic [31:0]      words_q [WORDS];
  logic [IDX_W-1:0] bin;
  logic [SEL_W-1:0] w_sel;
  logic [4:0]       b_sel;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [AW-1:0] W_A = AW'(HASH_BASE + w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           words_q[w] <= '0;
      else if (cfg_we_i && cfg_addr_i == W_A) words_q[w] <= cfg_wdata_i;
    end
  end

  assign bin   = IDX_W'(rev32(~da_crc32(da_i)) >> (32 - IDX_W));
  assign w_sel = bin[IDX_W-1:5];
  assign b_sel = bin[4:0];
  assign hit_o = words_q[w_sel][b_sel];

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_filter_pkg::*;
#(
  parameter int UC_ENTRIES = 4,
  parameter int HASH_BINS  = 64,
  parameter int CFG_AW     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic              sof_i,
  input  logic [7:0]        byte_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic              dec_valid_o,
  output logic              dec_accept_o
);
  localparam logic [CFG_AW-1:0] CTRL_A = CFG_AW'(CTRL_ADDR);
  localparam int CTRL_W = $bits(flt_ctrl_t);

  flt_ctrl_t       ctrl_q;
  logic [DA_W-1:0] da;
  logic            da_done, uc_hit, mc_hit;
  logic            is_group, is_bcast, accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ctrl_q <= '0;
    else if (cfg_we_i && cfg_addr_i == CTRL_A) ctrl_q <= flt_ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
  end

  da_capture i_cap (
    .clk_i, .rst_ni, .byte_valid_i, .sof_i, .byte_i,
    .da_o(da), .done_o(da_done)
  );

  uc_match #(.ENTRIES(UC_ENTRIES), .AW(CFG_AW)) i_uc (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .da_i(da), .hit_o(uc_hit)
  );

  mc_hash #(.BINS(HASH_BINS), .AW(CFG_AW)) i_mc (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .da_i(da), .hit_o(mc_hit)
  );

  assign is_group = da[0];
  assign is_bcast = &da;

  always_comb begin
    if (ctrl_q.recv_all || ctrl_q.promisc) accept = 1'b1;
    else if (is_bcast)                     accept = !ctrl_q.bcast_block;
    else if (is_group)                     accept = ctrl_q.all_mcast || (ctrl_q.hash_en && mc_hit);
    else                                   accept = uc_hit;
  end

  assign dec_valid_o  = da_done;
  assign dec_accept_o = da_done && accept;

  // R1
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);
  // R2
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && sof_i |=> !dec_valid_o);
  // R9
  recv_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && ctrl_q.recv_all |-> dec_accept_o);
  // R8
  promisc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && ctrl_q.promisc |-> dec_accept_o);
  // R7
  bcast_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && is_bcast && ctrl_q.bcast_block && !ctrl_q.promisc && !ctrl_q.recv_all
    |-> !dec_accept_o);
  // R3
  uc_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && !is_group && !uc_hit && !ctrl_q.promisc && !ctrl_q.recv_all
    |-> !dec_accept_o);

endmodule

// File: tb/test_rx_da_filter.sv
module test_rx_da_filter;
  localparam int CLK_PERIOD = 10;
  localparam int UC   = 4;
  localparam int BINS = 128;
  localparam int AW   = 6;
  localparam int HW   = BINS / 32;
  localparam int IDXW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bv = 0, sof = 0, we = 0;
  logic [7:0] bt = 0;
  logic [AW-1:0] adr = 0;
  logic [31:0] wd = 0;
  logic dv, da_acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_da_filter #(.UC_ENTRIES(UC), .HASH_BINS(BINS), .CFG_AW(AW)) i_rx_da_filter (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .sof_i(sof), .byte_i(bt),
    .cfg_we_i(we), .cfg_addr_i(adr), .cfg_wdata_i(wd),
    .dec_valid_o(dv), .dec_accept_o(da_acc)
  );

  int total = 0, fails = 0;
  bit finished = 0, reset_phase = 0;

  // behavioural model state
  bit [4:0]    m_ctrl;
  logic [31:0] m_hash [HW];
  logic [47:0] m_uc [UC];
  bit          m_en [UC];
  int          m_cnt;
  logic [7:0]  m_da [$];
  bit          m_pend;

  // R4: reflected CRC-32, inverted, reversed, top IDXW bits
  function automatic int model_bin(logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF, x, r;
    for (int k = 0; k < 6; k++)
      for (int j = 0; j < 8; j++) begin
        bit fb = c[0] ^ a[8*k+j];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    x = ~c;
    for (int i = 0; i < 32; i++) r[31-i] = x[i];
    return int'(r >> (32 - IDXW));
  endfunction

  function automatic bit decide(logic [47:0] a, output string tag);
    int b;
    if (m_ctrl[3]) begin tag = "R9"; return 1; end
    if (m_ctrl[0]) begin tag = "R8"; return 1; end
    if (a == '1) begin tag = "R7"; return !m_ctrl[4]; end
    if (a[0]) begin
      if (m_ctrl[1]) begin tag = "R6"; return 1; end
      tag = "R5";
      b = model_bin(a);
      return m_ctrl[2] && m_hash[b/32][b%32];
    end
    tag = "R3";
    for (int e = 0; e < UC; e++) if (m_en[e] && m_uc[e] == a) return 1;
    return 0;
  endfunction

  task automatic check();
    logic [47:0] a = '0;
    string tag;
    bit ea = 0;
    if (m_pend) begin
      for (int k = 0; k < 6; k++) a[8*k +: 8] = m_da[k];
      ea = decide(a, tag);
    end else tag = "R2";
    if (dv !== m_pend) tag = m_pend ? "R1" : "R2";
    if (reset_phase) tag = "R10";
    total++;
    if (dv !== m_pend || da_acc !== ea) begin
      fails++;
      $display("FAIL %s: valid/accept got %b/%b expected %b/%b (da=%h)", tag, dv, da_acc, m_pend, ea, a);
    end
  endtask

  task automatic cycle(input bit v, input bit s, input logic [7:0] b,
                       input bit w, input logic [AW-1:0] ad, input logic [31:0] d);
    int ai;
    @(negedge clk);
    check();
    bv = v; sof = s; bt = b; we = w; adr = ad; wd = d;
    @(posedge clk);
    m_pend = 0;
    if (v) begin
      if (s) begin m_da.delete(); m_da.push_back(b); m_cnt = 1; end
      else if (m_cnt >= 1 && m_cnt < 6) begin
        m_da.push_back(b); m_cnt++;
        if (m_cnt == 6) m_pend = 1;
      end
    end
    if (w) begin
      ai = int'(ad);
      if (ai == 0) m_ctrl = d[4:0];
      else if (ai >= 8 && ai < 8 + HW) m_hash[ai-8] = d;
      else if (ai >= 16 && ai < 16 + 2*UC) begin
        if (ai % 2 == 0) m_uc[(ai-16)/2][31:0] = d;
        else begin m_uc[(ai-16)/2][47:32] = d[15:0]; m_en[(ai-16)/2] = d[31]; end
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 8'h00, 0, '0, '0);
  endtask

  task automatic wr(int a, logic [31:0] d);
    cycle(0, 0, 8'h00, 1, AW'(a), d);
  endtask

  task automatic set_uc(int e, logic [47:0] a, bit en);
    wr(16 + 2*e, a[31:0]);
    wr(17 + 2*e, {en, 15'b0, a[47:32]});
  endtask

  task automatic set_bin(logic [47:0] a);
    int b = model_bin(a);
    wr(8 + b/32, m_hash[b/32] | (32'h1 << (b % 32)));
  endtask

  // R1/R2: nbytes of the address, gap idle cycles between bytes, extra trailing bytes
  task automatic send(logic [47:0] a, int nbytes, int gap, int extra);
    for (int k = 0; k < nbytes; k++) begin
      cycle(1, k == 0, a[8*k +: 8], 0, '0, '0);
      if (k < nbytes - 1) idle(gap);
    end
    for (int k = 0; k < extra; k++) cycle(1, 0, 8'($urandom), 0, '0, '0);
  endtask

  task automatic frame(logic [47:0] a);
    send(a, 6, 0, 2);
    idle(2);
  endtask

  localparam logic [47:0] STA   = 48'h5634_1200_0A02;
  localparam logic [47:0] UC1   = 48'h0102_0304_0506 & ~48'h1;
  localparam logic [47:0] UC2   = 48'hCAFE_F00D_BE00;
  localparam logic [47:0] UNK   = 48'h7777_6666_5544;
  localparam logic [47:0] MC1   = 48'h0100_005E_0001;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  initial begin
    logic [47:0] mc2;
    m_ctrl = 0; m_cnt = 0; m_pend = 0;
    for (int i = 0; i < HW; i++) m_hash[i] = '0;
    for (int e = 0; e < UC; e++) begin m_uc[e] = '0; m_en[e] = 0; end

    // R10: no strobe while in reset
    repeat (3) begin
      @(negedge clk); total++;
      if (dv !== 1'b0 || da_acc !== 1'b0) begin
        fails++; $display("FAIL R10: in reset got %b/%b expected 0/0", dv, da_acc);
      end
    end
    rst_n = 1'b1;
    reset_phase = 1;
    idle(2);
    frame(STA); frame(MC1); frame(BCAST);
    reset_phase = 0;

    // R3 exact table
    set_uc(0, STA, 1); set_uc(1, UC1, 1); set_uc(2, UC2, 0);
    frame(STA); frame(UC1); frame(UC2); frame(UNK);
    set_uc(2, UC2, 1); frame(UC2);

    // R4/R5 hash
    mc2 = MC1 ^ 48'h0000_0000_0100;
    frame(MC1);
    wr(0, 32'h4);
    frame(MC1);
    set_bin(MC1);
    frame(MC1); frame(mc2);
    for (int i = 0; i < 6; i++) begin
      logic [47:0] m = {$urandom, $urandom} | 48'h1;
      set_bin(m); frame(m);
    end
    wr(0, 32'h0); frame(MC1);

    // R6 pass-all-multicast
    wr(0, 32'h2); frame(mc2); frame(UNK); frame(STA);
    // R7 broadcast
    wr(0, 32'h0); frame(BCAST);
    wr(0, 32'h16); frame(BCAST);
    wr(0, 32'h10); frame(BCAST);
    // R8 promiscuous
    wr(0, 32'h11); frame(UNK); frame(BCAST); frame(mc2);
    // R9 receive-all
    wr(0, 32'h18); frame(UNK); frame(BCAST);
    wr(0, 32'h0);

    // R2 truncation, gaps, restart
    send(STA, 3, 0, 0); frame(UC1);
    send(UNK, 5, 1, 0); frame(STA);
    send(STA, 6, 3, 0); idle(3);
    send(UC1, 6, 0, 7); idle(2);
    send(STA, 1, 0, 0); send(STA, 6, 0, 0); idle(2);

    // mixed random traffic
    for (int it = 0; it < 400; it++) begin
      logic [47:0] a;
      int pick = $urandom_range(0, 7);
      case (pick)
        0: a = STA;
        1: a = UC1;
        2: a = UC2;
        3: a = BCAST;
        4: a = MC1;
        5: a = {$urandom, $urandom} | 48'h1;
        default: a = {$urandom, $urandom} & ~48'h1;
      endcase
      if ($urandom_range(0, 5) == 0) wr(0, $urandom & (($urandom_range(0, 3) == 0) ? 32'h1F : 32'h16));
      if ($urandom_range(0, 9) == 0) set_bin(a);
      if ($urandom_range(0, 7) == 0) send(a, $urandom_range(1, 5), $urandom_range(0, 1), 0);
      send(a, 6, $urandom_range(0, 2), $urandom_range(0, 3));
      idle($urandom_range(0, 2));
    end
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL R1: watchdog expired, got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", total, fails);
      $finish;
    end
  end

endmodule